// File: doc/BRIEF.md
# Graded Power-Mode Sequencer

This block is the always-on controller that moves a small system-on-chip between a running state and four sleep depths. The depths, from lightest to deepest, are wait, doze, state retention and hibernation. Each deeper depth saves more power and takes longer to wake. Software writes a target mode code. The controller then drives the enables for the core clock, the per-peripheral clocks, the PLL, the memory self-refresh request, the low-supply request and the main power switch. A wake input brings the system back to run.

The lightest depths only gate clocks. Wait stops the core clock. Doze also stops the peripherals that software marked beforehand in a gating mask. State retention hands the external memory to self-refresh and confirms it before it stops the clocks, turns the PLL off and lowers the supply. On wake it undoes each step in the reverse order, waiting on the supply-good and PLL-lock handshakes, so no data has to be restored. Hibernation removes main power from the chip. Software may enter it only after it has flagged that the state it needs was saved externally. Wake from hibernation powers up, relocks the PLL and issues a one-cycle cold-reset indication, exactly like a cold start.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, and whenever the controller is settled in run, the core clock, every peripheral clock, the PLL and main power are enabled, self-refresh and low-supply requests are low, `mode_o` is 0 and `busy_o` is 0.
- R2: Mode codes are run=0, wait=1, doze=2, retention=3, hibernate=4. A write sampled at one clock edge takes effect at the next edge. Code 1 gates only the core clock and reports mode 1. A wake then returns to run at the next edge. A wake while in run has no effect.
- R3: Code 2 gates the core clock, and it gates peripheral clock bit i exactly when bit i of the gating mask is 1. The mask is loaded through `mask_we_i`. The controller reports mode 2. A wake returns to run at the next edge, with all peripheral clocks enabled again.
- R4: Code 3 first raises the self-refresh request with all clocks and the PLL still on (busy, mode 0). Only at the edge where the self-refresh acknowledge is high does it gate all clocks, drop the PLL enable and raise the low-supply request.
- R5: Settled in retention, the controller shows all clocks off, PLL off, self-refresh and low-supply requests high, main power on, mode 3 and busy 0.
- R6: A wake in retention drops the low-supply request first. Once supply-good is high it enables the PLL. Once lock is high it ungates all clocks with self-refresh still held, and one cycle later it releases self-refresh in run. Mode stays 3 and busy stays 1 until run.
- R7: A wake while retention entry is waiting for the acknowledge, or during the one-cycle hibernation clock-gating step, aborts the entry and returns to run at the next edge.
- R8: A mode write that arrives while the controller is in a transition is held. It takes effect at the first edge after the controller is back in run. A later write replaces an earlier held one.
- R9: Code 4 with the state-saved input low is rejected: the controller stays in run and `err_o` goes to 1. The next write of a valid code clears `err_o`.
- R10: Code 4 with state-saved high gates clocks and the PLL for one cycle, then removes main power (mode 4, PLL, self-refresh and low-supply requests low). A wake restores power, waits for supply-good and then lock, enables the clocks with `cold_rst_o` high for exactly one cycle, and then returns to run.
- R11: Writes of codes 5, 6 and 7 are ignored: mode, outputs and `err_o` are unchanged.
- R12: `mode_o` changes only when the controller settles in a stable mode. `busy_o` is 1 in every intermediate step of a transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Mode write strobe |
| req_mode_i | input | 3 | Requested mode code |
| mask_we_i | input | 1 | Gating-mask write strobe |
| mask_i | input | NUM_PERIPH | Doze gating mask, 1 = gate that peripheral |
| state_saved_i | input | 1 | Software flag: state needed after hibernation is saved |
| wake_i | input | 1 | Interrupt or wake event |
| srf_ack_i | input | 1 | Memory self-refresh acknowledge |
| vdd_good_i | input | 1 | Supply at nominal level |
| pll_lock_i | input | 1 | PLL locked |
| core_clk_en_o | output | 1 | Core clock enable |
| periph_clk_en_o | output | NUM_PERIPH | Per-peripheral clock enables |
| pll_en_o | output | 1 | PLL enable |
| srf_req_o | output | 1 | Memory self-refresh request |
| low_vdd_req_o | output | 1 | Low-supply request |
| main_pwr_en_o | output | 1 | Main power switch enable |
| cold_rst_o | output | 1 | One-cycle cold-reset indication after hibernation |
| mode_o | output | 3 | Current settled mode code |
| busy_o | output | 1 | Transition in progress |
| err_o | output | 1 | Hibernation request rejected |

## Verification
The checks assume that the external handshakes are well behaved. The self-refresh acknowledge is seen only while the request is up. Supply-good and lock are seen only during the exit steps that wait for them. The checks also assume that no wake arrives in the same cycle as the acknowledge they would race. The bench holds each acknowledge, supply-good and lock high for a single cycle, only once the controller has reached the step that waits for it. It pulses wake only in settled sleep states or in the entry steps it means to abort. Mode writes are issued either from run or on purpose during an exit sequence to exercise holding.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   localparam int MODE_W   = 3;
   localparam int MAX_CODE = 4;

   typedef enum logic [MODE_W-1:0] {
      MODE_RUN  = 3'd0,
      MODE_WAIT = 3'd1,
      MODE_DOZE = 3'd2,
      MODE_RET  = 3'd3,
      MODE_HIB  = 3'd4
   } pmode_e;

   typedef enum logic [3:0] {
      SQ_RUN,
      SQ_WAIT,
      SQ_DOZE,
      SQ_RET_SRQ,
      SQ_RET,
      SQ_RET_VUP,
      SQ_RET_PLL,
      SQ_RET_CLK,
      SQ_HIB_GATE,
      SQ_HIB,
      SQ_HIB_PUP,
      SQ_HIB_PLL,
      SQ_HIB_RST
   } seq_e;

   // Actions requested from the surroundings in one sequencer step.
   typedef struct packed {
      logic core_clk;
      logic per_all;
      logic per_masked;
      logic pll;
      logic srf;
      logic lowv;
      logic pwr;
      logic cold;
   } act_t;

   function automatic logic seq_stable(input seq_e s);
      return (s == SQ_RUN) || (s == SQ_WAIT) || (s == SQ_DOZE) ||
             (s == SQ_RET) || (s == SQ_HIB);
   endfunction

   function automatic pmode_e seq_mode(input seq_e s);
      pmode_e m;
      case (s)
         SQ_WAIT:                       m = MODE_WAIT;
         SQ_DOZE:                       m = MODE_DOZE;
         SQ_RET, SQ_RET_VUP,
         SQ_RET_PLL, SQ_RET_CLK:        m = MODE_RET;
         SQ_HIB, SQ_HIB_PUP,
         SQ_HIB_PLL, SQ_HIB_RST:        m = MODE_HIB;
         default:                       m = MODE_RUN;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pwr_req_hold.sv
module pwr_req_hold #(
   parameter int MODE_W   = 3,
   parameter int MAX_CODE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [MODE_W-1:0] wr_mode,
   input  logic              take,
   input  logic              reject,
   output logic              pend_valid,
   output logic [MODE_W-1:0] pend_mode,
   output logic              err_flag
);

   localparam logic [MODE_W-1:0] LAST_CODE = MODE_W'(MAX_CODE);

   logic code_ok;
   logic load;

   assign code_ok = (wr_mode <= LAST_CODE);
   assign load    = wr_valid && code_ok;

   // Single held slot: the newest valid write replaces an older one.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_mode  <= '0;
      end else if (load) begin
         pend_valid <= 1'b1;
         pend_mode  <= wr_mode;
      end else if (take) begin
         pend_valid <= 1'b0;
      end
   end

   // Sticky rejection flag, cleared by the next valid write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_flag <= 1'b0;
      end else if (reject) begin
         err_flag <= 1'b1;
      end else if (load) begin
         err_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_mode_pkg::*;
#(
   parameter bit HIB_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend_valid,
   input  logic [MODE_W-1:0] pend_mode,
   input  logic              state_saved,
   input  logic              wake,
   input  logic              srf_ack,
   input  logic              vdd_good,
   input  logic              pll_lock,
   output seq_e              state_q,
   output logic              take,
   output logic              reject,
   output logic [MODE_W-1:0] mode_q
);

   seq_e nxt;
   logic hib_ok;

   generate
      if (HIB_SUPPORT) begin : g_hib
         assign hib_ok = state_saved;
      end else begin : g_no_hib
         logic unused_saved;
         assign unused_saved = state_saved;
         assign hib_ok       = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt    = state_q;
      take   = 1'b0;
      reject = 1'b0;
      unique case (state_q)
         SQ_RUN: begin
            if (pend_valid) begin
               take = 1'b1;
               case (pmode_e'(pend_mode))
                  MODE_WAIT: nxt = SQ_WAIT;
                  MODE_DOZE: nxt = SQ_DOZE;
                  MODE_RET:  nxt = SQ_RET_SRQ;
                  MODE_HIB: begin
                     if (hib_ok) nxt    = SQ_HIB_GATE;
                     else        reject = 1'b1;
                  end
                  default: ;
               endcase
            end
         end
         SQ_WAIT, SQ_DOZE: begin
            if (wake) nxt = SQ_RUN;
         end
         SQ_RET_SRQ: begin
            if (wake)         nxt = SQ_RUN;
            else if (srf_ack) nxt = SQ_RET;
         end
         SQ_RET: begin
            if (wake) nxt = SQ_RET_VUP;
         end
         SQ_RET_VUP: begin
            if (vdd_good) nxt = SQ_RET_PLL;
         end
         SQ_RET_PLL: begin
            if (pll_lock) nxt = SQ_RET_CLK;
         end
         SQ_RET_CLK: nxt = SQ_RUN;
         SQ_HIB_GATE: begin
            nxt = wake ? SQ_RUN : SQ_HIB;
         end
         SQ_HIB: begin
            if (wake) nxt = SQ_HIB_PUP;
         end
         SQ_HIB_PUP: begin
            if (vdd_good) nxt = SQ_HIB_PLL;
         end
         SQ_HIB_PLL: begin
            if (pll_lock) nxt = SQ_HIB_RST;
         end
         SQ_HIB_RST: nxt = SQ_RUN;
         default:    nxt = SQ_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_RUN;
      end else begin
         state_q <= nxt;
      end
   end

   // Reported mode moves only when a stable mode is reached.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_W'(MODE_RUN);
      end else if (seq_stable(nxt)) begin
         mode_q <= MODE_W'(seq_mode(nxt));
      end
   end

endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
   import pwr_mode_pkg::*;
#(
   parameter int NUM_PERIPH = 4
) (
   input  seq_e                  state,
   input  logic [NUM_PERIPH-1:0] gate_mask,
   output logic                  core_clk_en,
   output logic [NUM_PERIPH-1:0] periph_clk_en,
   output logic                  pll_en,
   output logic                  srf_req,
   output logic                  low_vdd_req,
   output logic                  main_pwr_en,
   output logic                  cold_rst
);

   act_t act;

   always_comb begin
      act = '0;
      unique case (state)
         SQ_RUN:      act = '{core_clk:1'b1, per_all:1'b1, per_masked:1'b0, pll:1'b1,
                              srf:1'b0, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_WAIT:     act = '{core_clk:1'b0, per_all:1'b1, per_masked:1'b0, pll:1'b1,
                              srf:1'b0, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_DOZE:     act = '{core_clk:1'b0, per_all:1'b0, per_masked:1'b1, pll:1'b1,
                              srf:1'b0, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_RET_SRQ:  act = '{core_clk:1'b1, per_all:1'b1, per_masked:1'b0, pll:1'b1,
                              srf:1'b1, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_RET:      act = '{core_clk:1'b0, per_all:1'b0, per_masked:1'b0, pll:1'b0,
                              srf:1'b1, lowv:1'b1, pwr:1'b1, cold:1'b0};
         SQ_RET_VUP:  act = '{core_clk:1'b0, per_all:1'b0, per_masked:1'b0, pll:1'b0,
                              srf:1'b1, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_RET_PLL:  act = '{core_clk:1'b0, per_all:1'b0, per_masked:1'b0, pll:1'b1,
                              srf:1'b1, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_RET_CLK:  act = '{core_clk:1'b1, per_all:1'b1, per_masked:1'b0, pll:1'b1,
                              srf:1'b1, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_HIB_GATE: act = '{core_clk:1'b0, per_all:1'b0, per_masked:1'b0, pll:1'b0,
                              srf:1'b0, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_HIB:      act = '0;
         SQ_HIB_PUP:  act = '{core_clk:1'b0, per_all:1'b0, per_masked:1'b0, pll:1'b0,
                              srf:1'b0, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_HIB_PLL:  act = '{core_clk:1'b0, per_all:1'b0, per_masked:1'b0, pll:1'b1,
                              srf:1'b0, lowv:1'b0, pwr:1'b1, cold:1'b0};
         SQ_HIB_RST:  act = '{core_clk:1'b1, per_all:1'b1, per_masked:1'b0, pll:1'b1,
                              srf:1'b0, lowv:1'b0, pwr:1'b1, cold:1'b1};
         default:     act = '{core_clk:1'b1, per_all:1'b1, per_masked:1'b0, pll:1'b1,
                              srf:1'b0, lowv:1'b0, pwr:1'b1, cold:1'b0};
      endcase
   end

   generate
      for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_per
         assign periph_clk_en[i] = act.per_all | (act.per_masked & ~gate_mask[i]);
      end
   endgenerate

   assign core_clk_en = act.core_clk;
   assign pll_en      = act.pll;
   assign srf_req     = act.srf;
   assign low_vdd_req = act.lowv;
   assign main_pwr_en = act.pwr;
   assign cold_rst    = act.cold;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int NUM_PERIPH  = 4,
   parameter bit HIB_SUPPORT = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid_i,
   input  logic [2:0]            req_mode_i,
   input  logic                  mask_we_i,
   input  logic [NUM_PERIPH-1:0] mask_i,
   input  logic                  state_saved_i,
   input  logic                  wake_i,
   input  logic                  srf_ack_i,
   input  logic                  vdd_good_i,
   input  logic                  pll_lock_i,
   output logic                  core_clk_en_o,
   output logic [NUM_PERIPH-1:0] periph_clk_en_o,
   output logic                  pll_en_o,
   output logic                  srf_req_o,
   output logic                  low_vdd_req_o,
   output logic                  main_pwr_en_o,
   output logic                  cold_rst_o,
   output logic [2:0]            mode_o,
   output logic                  busy_o,
   output logic                  err_o
);

   generate
      if (NUM_PERIPH < 1 || NUM_PERIPH > 64) begin : g_bad_np
         $error("pwr_mode_ctrl: NUM_PERIPH must lie in 1..64");
      end
   endgenerate

   logic                  pend_valid;
   logic [MODE_W-1:0]     pend_mode;
   logic                  take;
   logic                  reject;
   seq_e                  state;
   logic [NUM_PERIPH-1:0] gate_mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_mask_q <= '0;
      end else if (mask_we_i) begin
         gate_mask_q <= mask_i;
      end
   end

   pwr_req_hold #(
      .MODE_W   (MODE_W),
      .MAX_CODE (MAX_CODE)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_valid   (req_valid_i),
      .wr_mode    (req_mode_i),
      .take       (take),
      .reject     (reject),
      .pend_valid (pend_valid),
      .pend_mode  (pend_mode),
      .err_flag   (err_o)
   );

   pwr_seq_fsm #(
      .HIB_SUPPORT (HIB_SUPPORT)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .pend_valid  (pend_valid),
      .pend_mode   (pend_mode),
      .state_saved (state_saved_i),
      .wake        (wake_i),
      .srf_ack     (srf_ack_i),
      .vdd_good    (vdd_good_i),
      .pll_lock    (pll_lock_i),
      .state_q     (state),
      .take        (take),
      .reject      (reject),
      .mode_q      (mode_o)
   );

   pwr_out_dec #(
      .NUM_PERIPH (NUM_PERIPH)
   ) u_dec (
      .state         (state),
      .gate_mask     (gate_mask_q),
      .core_clk_en   (core_clk_en_o),
      .periph_clk_en (periph_clk_en_o),
      .pll_en        (pll_en_o),
      .srf_req       (srf_req_o),
      .low_vdd_req   (low_vdd_req_o),
      .main_pwr_en   (main_pwr_en_o),
      .cold_rst      (cold_rst_o)
   );

   assign busy_o = !seq_stable(state);

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
   parameter int NUM_PERIPH = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wake_i,
   input logic                  srf_ack_i,
   input logic                  core_clk_en_o,
   input logic [NUM_PERIPH-1:0] periph_clk_en_o,
   input logic                  pll_en_o,
   input logic                  srf_req_o,
   input logic                  low_vdd_req_o,
   input logic                  main_pwr_en_o,
   input logic                  cold_rst_o,
   input logic [2:0]            mode_o,
   input logic                  busy_o,
   input logic                  err_o
);

   AST_RUN_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && mode_o == 3'd0) |-> (core_clk_en_o && (&periph_clk_en_o) && pll_en_o && !srf_req_o)); // R1

   AST_WAIT_CORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && mode_o == 3'd1) |-> (!core_clk_en_o && (&periph_clk_en_o))); // R2

   AST_WAIT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && mode_o == 3'd1 && wake_i) |=> (mode_o == 3'd0 && !busy_o)); // R2

   AST_LOWV_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(low_vdd_req_o) |-> $past(srf_ack_i)); // R4

   AST_NO_CLK_WITHOUT_PLL: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en_o |-> (!core_clk_en_o && periph_clk_en_o == '0)); // R4

   AST_LOWV_IN_SRF: assert property (@(posedge clk) disable iff (!rst_n)
      low_vdd_req_o |-> srf_req_o); // R5

   AST_SRF_RELEASE_CLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(srf_req_o) && main_pwr_en_o) |-> core_clk_en_o); // R6

   AST_ERR_STAYS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (mode_o == 3'd0 && !busy_o)); // R9

   AST_COLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cold_rst_o |=> !cold_rst_o); // R10

   AST_COLD_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      cold_rst_o |-> (main_pwr_en_o && pll_en_o && core_clk_en_o)); // R10

   AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !main_pwr_en_o |-> (!pll_en_o && !srf_req_o && !low_vdd_req_o)); // R10

   AST_MODE_SETTLED_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $changed(mode_o)) |-> (mode_o <= 3'd4)); // R12

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
   .NUM_PERIPH (NUM_PERIPH)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wake_i          (wake_i),
   .srf_ack_i       (srf_ack_i),
   .core_clk_en_o   (core_clk_en_o),
   .periph_clk_en_o (periph_clk_en_o),
   .pll_en_o        (pll_en_o),
   .srf_req_o       (srf_req_o),
   .low_vdd_req_o   (low_vdd_req_o),
   .main_pwr_en_o   (main_pwr_en_o),
   .cold_rst_o      (cold_rst_o),
   .mode_o          (mode_o),
   .busy_o          (busy_o),
   .err_o           (err_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

   localparam int NP = 4;
   localparam int VW = NP + 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_mode = 3'd0;
   logic          mask_we = 1'b0;
   logic [NP-1:0] mask = '0;
   logic          saved = 1'b0;
   logic          wake = 1'b0;
   logic          srf_ack = 1'b0;
   logic          vdd_good = 1'b0;
   logic          pll_lock = 1'b0;

   logic          core_en;
   logic [NP-1:0] per_en;
   logic          pll_en;
   logic          srf_req;
   logic          lowv;
   logic          pwr_en;
   logic          cold;
   logic [2:0]    mode;
   logic          busy;
   logic          err;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pwr_mode_ctrl #(.NUM_PERIPH(NP)) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .req_valid_i     (req_valid),
      .req_mode_i      (req_mode),
      .mask_we_i       (mask_we),
      .mask_i          (mask),
      .state_saved_i   (saved),
      .wake_i          (wake),
      .srf_ack_i       (srf_ack),
      .vdd_good_i      (vdd_good),
      .pll_lock_i      (pll_lock),
      .core_clk_en_o   (core_en),
      .periph_clk_en_o (per_en),
      .pll_en_o        (pll_en),
      .srf_req_o       (srf_req),
      .low_vdd_req_o   (lowv),
      .main_pwr_en_o   (pwr_en),
      .cold_rst_o      (cold),
      .mode_o          (mode),
      .busy_o          (busy),
      .err_o           (err)
   );

   function automatic logic [VW-1:0] ev(input logic c, input logic [NP-1:0] p,
                                         input logic pl, input logic sr, input logic lv,
                                         input logic pw, input logic cd, input logic [2:0] md,
                                         input logic by, input logic er);
      return {c, p, pl, sr, lv, pw, cd, md, by, er};
   endfunction

   function automatic logic [VW-1:0] ev_run(input logic er);
      return ev(1'b1, '1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, er);
   endfunction

   task automatic chk(input string tag, input logic [VW-1:0] expv);
      logic [VW-1:0] act;
      act = {core_en, per_en, pll_en, srf_req, lowv, pwr_en, cold, mode, busy, err};
      n_run++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Write a code; returns at the negedge after the edge where it takes effect.
   task automatic wr_req(input logic [2:0] code);
      req_valid = 1'b1;
      req_mode  = code;
      tick(1);
      req_valid = 1'b0;
      tick(1);
   endtask

   task automatic pulse_wake();
      wake = 1'b1;
      tick(1);
      wake = 1'b0;
   endtask

   task automatic pulse_ack();
      srf_ack = 1'b1;
      tick(1);
      srf_ack = 1'b0;
   endtask

   task automatic pulse_vgood();
      vdd_good = 1'b1;
      tick(1);
      vdd_good = 1'b0;
   endtask

   task automatic pulse_lock();
      pll_lock = 1'b1;
      tick(1);
      pll_lock = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(2);
      chk("R1 in reset", ev_run(1'b0));
      rst_n = 1'b1;
      tick(2);
      chk("R1 after reset", ev_run(1'b0));

      // R2 wait mode, and wake ignored in run
      pulse_wake();
      chk("R2 wake in run", ev_run(1'b0));
      wr_req(3'd1);
      chk("R2 wait entered", ev(1'b0, '1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0));
      tick(3);
      chk("R2 wait holds", ev(1'b0, '1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0));
      pulse_wake();
      chk("R2 wait to run", ev_run(1'b0));

      // R3 doze: exhaustive mask sweep
      for (int m = 0; m < (1 << NP); m++) begin
         mask_we = 1'b1;
         mask    = NP'(m);
         tick(1);
         mask_we = 1'b0;
         mask    = '0;
         chk("R3 mask load keeps run", ev_run(1'b0));
         wr_req(3'd2);
         chk("R3 doze gating", ev(1'b0, ~NP'(m), 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0, 1'b0));
         pulse_wake();
         chk("R3 doze wake", ev_run(1'b0));
      end

      // R4 retention entry ordering
      wr_req(3'd3);
      chk("R4 srf first", ev(1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0));
      tick(3);
      chk("R4 waits for ack", ev(1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0));
      pulse_ack();
      chk("R5 retention settled", ev(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0));
      tick(2);
      chk("R5 retention holds", ev(1'b0, '0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 1'b0));

      // R6 retention exit ordering
      pulse_wake();
      chk("R6 supply up", ev(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0));
      tick(2);
      chk("R6 waits supply-good", ev(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0));
      pulse_vgood();
      chk("R6 pll on", ev(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0));
      tick(2);
      chk("R6 waits lock", ev(1'b0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0));
      pulse_lock();
      chk("R6 clocks before srf release", ev(1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0));
      tick(1);
      chk("R6 back in run", ev_run(1'b0));

      // R7 abort retention entry
      wr_req(3'd3);
      chk("R7 entry pending ack", ev(1'b1, '1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0));
      pulse_wake();
      chk("R7 retention abort", ev_run(1'b0));

      // R8 request held during exit sequence
      wr_req(3'd3);
      pulse_ack();
      pulse_wake();
      req_valid = 1'b1;
      req_mode  = 3'd2;
      tick(1);
      req_mode  = 3'd1;
      tick(1);
      req_valid = 1'b0;
      chk("R8 held while busy", ev(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 1'b0));
      pulse_vgood();
      pulse_lock();
      tick(1);
      chk("R8 run reached first", ev_run(1'b0));
      tick(1);
      chk("R8 latest held request applied", ev(1'b0, '1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1, 1'b0, 1'b0));
      pulse_wake();
      chk("R8 wake after held", ev_run(1'b0));

      // R9 hibernation rejected without saved state
      saved = 1'b0;
      wr_req(3'd4);
      chk("R9 reject sets err", ev_run(1'b1));
      tick(2);
      chk("R9 err sticky", ev_run(1'b1));

      // R11 invalid codes ignored (err stays set)
      for (int c = 5; c < 8; c++) begin
         wr_req(3'(c));
         chk("R11 invalid code ignored", ev_run(1'b1));
      end

      // R10 hibernation entry and cold exit; valid write clears err (R9)
      saved = 1'b1;
      wr_req(3'd4);
      chk("R10 gate step and R9 err cleared",
          ev(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0));
      tick(1);
      chk("R10 power off", ev(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0));
      tick(2);
      chk("R10 off holds", ev(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 1'b0));
      pulse_wake();
      chk("R10 power up", ev(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0));
      pulse_vgood();
      chk("R10 pll on", ev(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 1'b1, 1'b0));
      pulse_lock();
      chk("R10 cold reset pulse", ev(1'b1, '1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4, 1'b1, 1'b0));
      tick(1);
      chk("R10 run after cold", ev_run(1'b0));

      // R7 abort hibernation during gate step
      wr_req(3'd4);
      chk("R7 hib gate step", ev(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 1'b0));
      pulse_wake();
      chk("R7 hib abort", ev_run(1'b0));

      // R12 run code from run is a no-op and mode stays settled
      wr_req(3'd0);
      chk("R12 run code no-op", ev_run(1'b0));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule